// File: doc/BRIEF.md
# Blocked LU Loop Index Generator

This block produces the stream of index triples that sequences a blocked LU decomposition of an N×N matrix stored on chip, where the arithmetic works on K adjacent columns at once. Each triple is (i, k, j). The pivot row i is the outermost index. The column block start k is the middle index and moves in steps of K. The updated row j is the innermost index. For each pivot, the middle loop begins at the block that holds the pivot column, so blocks wholly to its left are never visited.

A single start pulse launches a full run. The matrix order and the lane count come in as run-time exponents and are captured when the run starts. Triples leave through a valid/ready handshake at one per cycle. A triple reaches the output two cycles after the internal counters form it. A one-cycle done pulse follows the acceptance of the final triple. The block computes no addresses and holds no matrix data.

Top module: `lu_idx_gen`

## Requirements
- R1: After reset, out_valid and done are low.
- R2: Triples appear in nested order. Pivot i runs 1..N (outer). For each i, k runs over the block starts (middle). For each k, j runs i..N (inner). No triple is repeated or skipped.
- R3: For pivot i, k starts at floor((i-1)/K)*K and rises by K up to and including N-K. Columns are counted from 0.
- R4: Order and lane count are encoded as follows. N = 2^n_log2, with n_log2 from 0 to 7. k_sel is 0 for K=4, 1 for K=8, 2 for K=16, and the value 3 also selects K=16. Both are captured at the start that is taken.
- R5: The first triple is valid on the output after the second clock edge that follows the edge sampling start. While out_ready stays high, a new triple is presented every cycle with no gaps.
- R6: While out_valid is high and out_ready is low, the presented triple and out_last hold steady and out_valid stays high.
- R7: out_last is high only with the final triple (i=N, k=N-K, j=N).
- R8: done is high for exactly one cycle, in the cycle after the final triple is accepted. After that, out_valid stays low until a new start is taken.
- R9: A start during a run is ignored, and so are changes of n_log2 or k_sel during a run. The sequence in progress continues unchanged.
- R10: A start whose configuration gives N < K is ignored. No triple is produced and done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a run when idle |
| n_log2 | input | 3 | Matrix order exponent, N = 2^n_log2 |
| k_sel | input | 2 | Lane count select (4, 8, 16, 16) |
| out_ready | input | 1 | Consumer accepts the presented triple |
| out_valid | output | 1 | A triple is presented |
| out_i | output | 8 | Pivot row, 1-based |
| out_k | output | 7 | Column block start, 0-based |
| out_j | output | 8 | Updated row, 1-based |
| out_last | output | 1 | Presented triple is the final one |
| done | output | 1 | One-cycle pulse after the final acceptance |

## Verification
A wrong counter carry shows at the ports two cycles later as a triple that differs from the software nested-loop model. Typical cases are a k that does not restart at the pivot's block or a j that restarts from 1 instead of i. The bench compares every accepted triple against that model for several order and lane pairs, under both steady and irregular ready. A fault in the stall path shows in the first cycle of back-pressure as a changed held triple. A fault in the end detection shows as a missing, early or repeated done, or as a count of accepted triples that does not match the model.

// File: rtl/lu_idx_pkg.sv
package lu_idx_pkg;
  parameter int MAX_N_LOG2 = 7;
  localparam int IDX_W  = MAX_N_LOG2 + 1;
  localparam int BLK_W  = MAX_N_LOG2;
  localparam int NL_W   = $clog2(MAX_N_LOG2 + 1);
  localparam int KSEL_W = 2;

  typedef struct packed {
    logic [IDX_W-1:0] row_i;
    logic [BLK_W-1:0] blk_k;
    logic [IDX_W-1:0] row_j;
    logic             fin;
  } triple_t;

  localparam int TRIPLE_W = $bits(triple_t);

  // lane-count exponent for a select code; code 3 aliases 16 lanes
  function automatic logic [NL_W-1:0] lanes_log2(input logic [KSEL_W-1:0] sel);
    case (sel)
      2'd0:    return NL_W'(2);
      2'd1:    return NL_W'(3);
      default: return NL_W'(4);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] pow2(input logic [NL_W-1:0] e);
    return IDX_W'(1) << e;
  endfunction

  // start column of the block holding 1-based column piv
  function automatic logic [BLK_W-1:0] first_block(input logic [IDX_W-1:0] piv,
                                                    input logic [NL_W-1:0]  kl);
    return BLK_W'(((piv - IDX_W'(1)) >> kl) << kl);
  endfunction

  function automatic logic [BLK_W-1:0] last_block(input logic [NL_W-1:0] nl,
                                                   input logic [NL_W-1:0] kl);
    return BLK_W'(pow2(nl) - pow2(kl));
  endfunction
endpackage

// File: rtl/lu_idx_step.sv
module lu_idx_step
  import lu_idx_pkg::*;
(
  input  logic [IDX_W-1:0] cur_i,
  input  logic [BLK_W-1:0] cur_k,
  input  logic [IDX_W-1:0] cur_j,
  input  logic [NL_W-1:0]  n_log2,
  input  logic [NL_W-1:0]  k_log2,
  output logic [IDX_W-1:0] nxt_i,
  output logic [BLK_W-1:0] nxt_k,
  output logic [IDX_W-1:0] nxt_j,
  output logic             fin
);
  logic [IDX_W-1:0] n_val;
  logic [BLK_W-1:0] k_step;
  logic [BLK_W-1:0] k_top;
  logic             row_end;
  logic             blk_end;
  logic             piv_end;

  assign n_val   = pow2(n_log2);
  assign k_step  = BLK_W'(pow2(k_log2));
  assign k_top   = last_block(n_log2, k_log2);
  assign row_end = (cur_j == n_val);
  assign blk_end = (cur_k == k_top);
  assign piv_end = (cur_i == n_val);
  assign fin     = row_end & blk_end & piv_end;

  always_comb begin
    nxt_i = cur_i;
    nxt_k = cur_k;
    nxt_j = cur_j;
    if (!row_end) begin
      nxt_j = cur_j + IDX_W'(1);
    end else if (!blk_end) begin
      nxt_k = cur_k + k_step;
      nxt_j = cur_i;
    end else if (!piv_end) begin
      nxt_i = cur_i + IDX_W'(1);
      nxt_k = first_block(cur_i + IDX_W'(1), k_log2);
      nxt_j = cur_i + IDX_W'(1);
    end
  end
endmodule

// File: rtl/lu_idx_pipe.sv
module lu_idx_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         any_valid
);
  logic [DEPTH-1:0] v_q;
  logic [W-1:0]     d_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic         v_in;
    logic [W-1:0] d_in;
    if (s == 0) begin : g_head
      assign v_in = in_valid;
      assign d_in = in_data;
    end else begin : g_body
      assign v_in = v_q[s-1];
      assign d_in = d_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0;
        d_q[s] <= '0;
      end else if (adv) begin
        v_q[s] <= v_in;
        d_q[s] <= d_in;
      end
    end
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_data  = d_q[DEPTH-1];
  assign any_valid = |v_q;

  a_r6_stall_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && out_valid) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/lu_idx_gen.sv
module lu_idx_gen
  import lu_idx_pkg::*;
#(
  parameter int PIPE_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NL_W-1:0]     n_log2,
  input  logic [KSEL_W-1:0]   k_sel,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [IDX_W-1:0]    out_i,
  output logic [BLK_W-1:0]    out_k,
  output logic [IDX_W-1:0]    out_j,
  output logic                out_last,
  output logic                done
);
  logic             run_q;
  logic [IDX_W-1:0] gen_i, gen_j;
  logic [BLK_W-1:0] gen_k;
  logic [NL_W-1:0]  cfg_nl_q, cfg_kl_q;
  logic             done_q;

  logic [IDX_W-1:0] nxt_i, nxt_j;
  logic [BLK_W-1:0] nxt_k;
  logic             step_fin;

  logic [NL_W-1:0]  req_kl;
  logic             cfg_ok, busy, pipe_busy;
  logic             start_take, start_drop;
  logic             adv, gen_fire, accept;
  triple_t          pipe_in, pipe_out;
  logic [TRIPLE_W-1:0] pipe_vec;

  assign req_kl     = lanes_log2(k_sel);
  assign cfg_ok     = (n_log2 >= req_kl);
  assign busy       = run_q | pipe_busy;
  assign start_take = start & ~busy & cfg_ok;
  assign start_drop = start & ~busy & ~cfg_ok;
  assign adv        = ~out_valid | out_ready;
  assign gen_fire   = run_q & adv;
  assign accept     = out_valid & out_ready;

  lu_idx_step u_step (
    .cur_i (gen_i),
    .cur_k (gen_k),
    .cur_j (gen_j),
    .n_log2(cfg_nl_q),
    .k_log2(cfg_kl_q),
    .nxt_i (nxt_i),
    .nxt_k (nxt_k),
    .nxt_j (nxt_j),
    .fin   (step_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      gen_i    <= '0;
      gen_k    <= '0;
      gen_j    <= '0;
      cfg_nl_q <= '0;
      cfg_kl_q <= '0;
    end else if (start_take) begin
      run_q    <= 1'b1;
      gen_i    <= IDX_W'(1);
      gen_k    <= '0;
      gen_j    <= IDX_W'(1);
      cfg_nl_q <= n_log2;
      cfg_kl_q <= req_kl;
    end else if (gen_fire) begin
      if (step_fin) begin
        run_q <= 1'b0;
      end else begin
        gen_i <= nxt_i;
        gen_k <= nxt_k;
        gen_j <= nxt_j;
      end
    end
  end

  assign pipe_in = '{row_i: gen_i, blk_k: gen_k, row_j: gen_j, fin: step_fin};

  lu_idx_pipe #(.W(TRIPLE_W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .in_valid (run_q),
    .in_data  (pipe_in),
    .out_valid(out_valid),
    .out_data (pipe_vec),
    .any_valid(pipe_busy)
  );

  assign pipe_out = pipe_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= accept & pipe_out.fin;
  end

  assign out_i    = pipe_out.row_i;
  assign out_k    = pipe_out.blk_k;
  assign out_j    = pipe_out.row_j;
  assign out_last = pipe_out.fin;
  assign done     = done_q;

  a_r2_row_not_above_pivot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_j >= out_i));

  a_r3_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_k & BLK_W'(pow2(cfg_kl_q) - IDX_W'(1))) == '0));

  a_r8_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && out_last) |=> done);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !run_q));

  a_r10_bad_cfg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start_drop |=> !run_q);

  a_r9_run_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !gen_fire) |=> ($stable(gen_i) && $stable(gen_k) && $stable(gen_j)));
endmodule

// File: tb/lu_idx_gen_tb.sv
module lu_idx_gen_tb;
  import lu_idx_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NL_W-1:0] n_log2 = '0;
  logic [KSEL_W-1:0] k_sel = '0;
  logic out_ready = 1'b0;
  logic out_valid, out_last, done;
  logic [IDX_W-1:0] out_i, out_j;
  logic [BLK_W-1:0] out_k;

  int n_chk = 0;
  int n_fail = 0;
  int total_cyc = 0;
  bit finished = 1'b0;
  int exp_q[$];
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  lu_idx_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_log2(n_log2), .k_sel(k_sel),
    .out_ready(out_ready), .out_valid(out_valid), .out_i(out_i), .out_k(out_k),
    .out_j(out_j), .out_last(out_last), .done(done)
  );

  always @(posedge clk) begin
    lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    total_cyc <= total_cyc + 1;
    if (total_cyc > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000 cycles", total_cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  function automatic int pack3(input int i, input int k, input int j);
    return (i << 16) | (k << 8) | j;
  endfunction

  task automatic build(input int n, input int kl);
    exp_q.delete();
    for (int i = 1; i <= n; i++)
      for (int kb = ((i - 1) / kl) * kl; kb <= n - kl; kb += kl)
        for (int j = i; j <= n; j++)
          exp_q.push_back(pack3(i, kb, j));
  endtask

  task automatic run_cfg(input int nl, input int ks, input int kval,
                         input bit throttle, input bit poke);
    int idx = 0;
    bit held = 0;
    bit seen_done = 0;
    int prev = 0;
    int got;
    bit rdy;
    build(1 << nl, kval);
    @(negedge clk);
    n_log2 = NL_W'(nl); k_sel = KSEL_W'(ks); start = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(out_valid == 1'b0, "R5 not valid one edge after start", int'(out_valid), 0);
    for (int cyc = 0; cyc < 40000; cyc++) begin
      @(negedge clk);
      if (cyc == 1)
        chk(out_valid == 1'b1, "R5 first triple two edges after start", int'(out_valid), 1);
      if (idx == exp_q.size()) begin
        chk(done == 1'b1, "R8 done in cycle after final accept", int'(done), 1);
        seen_done = 1;
        break;
      end
      if (done) chk(1'b0, "R8 early done", idx, exp_q.size());
      if (poke && cyc == 20) begin
        start = 1'b1; n_log2 = NL_W'(nl - 1); k_sel = 2'd0;
      end else begin
        start = 1'b0;
      end
      got = pack3(int'(out_i), int'(out_k), int'(out_j));
      if (held)
        chk(out_valid && got == prev, "R6 held triple stable", got, prev);
      rdy = throttle ? (lf[0] | lf[5]) : 1'b1;
      out_ready = rdy;
      if (out_valid) begin
        chk(got == exp_q[idx], "R2 R3 R4 R9 triple order", got, exp_q[idx]);
        chk(out_last == (idx == exp_q.size() - 1), "R7 last flag", int'(out_last),
            int'(idx == exp_q.size() - 1));
        if (rdy) idx++;
      end else if (!throttle && cyc >= 1) begin
        chk(1'b0, "R5 gap while ready high", idx, exp_q.size());
      end
      held = out_valid && !rdy;
      prev = got;
    end
    if (!seen_done) chk(1'b0, "R8 run never finished", idx, exp_q.size());
    start = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!done && !out_valid, "R8 idle after done", int'(done) * 2 + int'(out_valid), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !done, "R1 reset state", int'(out_valid) * 2 + int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done, "R1 state after reset release", int'(out_valid) * 2 + int'(done), 0);

    run_cfg(2, 0, 4, 1'b0, 1'b0);   // N=4  K=4
    run_cfg(3, 0, 4, 1'b0, 1'b0);   // N=8  K=4
    run_cfg(4, 1, 8, 1'b0, 1'b1);   // N=16 K=8, start poked mid-run (R9)
    run_cfg(5, 2, 16, 1'b1, 1'b0);  // N=32 K=16, throttled ready
    run_cfg(4, 3, 16, 1'b0, 1'b0);  // N=16, select code 3 gives K=16 (R4)
    run_cfg(5, 0, 4, 1'b1, 1'b0);   // N=32 K=4, throttled
    run_cfg(6, 2, 16, 1'b1, 1'b0);  // N=64 K=16, throttled

    // R10: N=4 with K=16 is not accepted
    @(negedge clk);
    n_log2 = 3'd2; k_sel = 2'd2; start = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(!out_valid && !done, "R10 invalid config ignored",
          int'(out_valid) * 2 + int'(done), 0);
    end
    run_cfg(2, 0, 4, 1'b0, 1'b0);   // still accepts a valid start afterwards

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule